// File: doc/BRIEF.md
# Page Write Buffer and Programming Controller

This block sits between the byte-level decoder of a serial memory slave and its nonvolatile array. While a write command is in progress it stores each received data byte in a sixteen-entry page store indexed by the low four address bits. The first byte's address fixes the page, which is address bits 9:4, and the starting slot. Each following byte moves to the next slot. The slot number wraps from 15 to 0 and never carries into the page bits, so a seventeenth byte replaces the first one.

When a STOP strobe closes a command that delivered at least one byte, the block enters a programming cycle. It raises `busy` for exactly `TWR_CYCLES` clock cycles, which model the internal write time. During the first sixteen of those cycles it scans the slots in ascending order and emits one commit strobe for each slot that received data. While `busy` is high every incoming strobe is ignored.

A START/abort strobe before STOP discards the collected bytes. The write-protect input has no effect until the first data byte is taken. From that byte onward, either write-protect or the low-voltage inhibit cancels the command. If the cancel arrives during the programming cycle, `busy` drops on the next edge and no further commits are issued.

The controller has five states:
- **IDLE**: no command in progress.
- **FILL**: bytes are being collected.
- **HOLD**: the command was cancelled before STOP, and the block waits for STOP or START.
- **COMMIT**: the slot scan.
- **WAIT**: the remainder of the programming time.

Its transitions are:
- **take-first** (IDLE→FILL on a byte with no inhibit).
- **refuse-first** (IDLE→HOLD on a byte with an inhibit).
- **discard** (FILL→IDLE on abort, or on STOP with an inhibit).
- **cancel-fill** (FILL→HOLD on an inhibit).
- **launch** (FILL→COMMIT on STOP).
- **release** (HOLD→IDLE on STOP or abort).
- **scan-done** (COMMIT→WAIT after slot 15).
- **kill** (COMMIT/WAIT→IDLE on an inhibit).
- **finish** (WAIT→IDLE when the timer expires).

`TWR_CYCLES` must exceed 16.

Top module: `pgwr_commit`

## Requirements
- R1: After reset, `busy` and `cm_vld` are low.
- R2: The k-th byte of a command (k counted from 0) goes to address {start_addr[9:4], (start_addr[3:0]+k) mod 16`}`. Commits are issued in ascending order of the low four address bits, and all commits of one cycle share bits 9:4.
- R3: When more than 16 bytes arrive, each slot keeps the last byte written to it, and at most 16 commits are issued.
- R4: A STOP strobe in FILL raises `busy` in the cycle after the strobe, and `busy` then stays high for exactly `TWR_CYCLES` cycles.
- R5: Only slots that received a byte are committed, one per cycle, within the first 16 busy cycles. A STOP with no preceding byte starts no cycle and issues no commit.
- R6: While `busy` is high, byte, STOP and abort strobes have no effect on the running cycle or on the next command.
- R7: An abort strobe before STOP discards the bytes, so a later STOP commits nothing.
- R8: `wp` high before the first data byte of a command has no effect.
- R9: `wp` high in the cycle of the first byte, or in any later cycle before STOP, cancels the command: no busy cycle and no commit.
- R10: `wp` high during `busy` blocks `cm_vld` in that cycle and makes `busy` fall on the next edge, with no later commit.
- R11: `lv_inhibit` high at STOP or during `busy` blocks programming in the same way as `wp`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| byte_vld | input | 1 | One-cycle strobe: a data byte was received |
| byte_data | input | 8 | Data byte |
| start_addr | input | 10 | Word address of the command's first byte |
| stop_stb | input | 1 | One-cycle STOP strobe |
| abort_stb | input | 1 | One-cycle START/abort strobe |
| wp | input | 1 | Write-protect level |
| lv_inhibit | input | 1 | Low-supply inhibit level |
| busy | output | 1 | Programming cycle in progress |
| cm_vld | output | 1 | Commit strobe toward the array |
| cm_addr | output | 10 | Commit address |
| cm_data | output | 8 | Commit data |

## Verification
Each fault shows up at the ports within one programming cycle.
- A wrong slot index or a lost valid bit appears at once as a missing, extra or misaddressed commit among the first sixteen busy cycles.
- A wrong state transition appears as a `busy` pulse of the wrong length or in the wrong place: a discarded command that still programs, or a killed cycle that keeps `busy` high one edge too long.
- A stale nibble counter appears in the next command's commit addresses.

// File: rtl/pgwr_pkg.sv
package pgwr_pkg;

    typedef enum logic [2:0] {
        ST_IDLE   = 3'd0,
        ST_FILL   = 3'd1,
        ST_HOLD   = 3'd2,
        ST_COMMIT = 3'd3,
        ST_WAIT   = 3'd4
    } pg_state_t;

endpackage

// File: rtl/pgwr_buffer.sv
module pgwr_buffer #(
    parameter int DATA_W = 8,
    parameter int IDX_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              clr,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [DATA_W-1:0] rd_data,
    output logic              rd_valid
);
    localparam int DEPTH = 1 << IDX_W;

    logic [DATA_W-1:0] slot_q  [DEPTH];
    logic [DEPTH-1:0]  filled_q;

    // Slot storage: a clear and a write in the same cycle leave only the new slot marked.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            filled_q <= '0;
            for (int i = 0; i < DEPTH; i++) slot_q[i] <= '0;
        end else begin
            if (clr) filled_q <= '0;
            if (wr_en) begin
                filled_q[wr_idx] <= 1'b1;
                slot_q[wr_idx]   <= wr_data;
            end
        end
    end

    // Read port: one mux per data bit, built by generate.
    for (genvar b = 0; b < DATA_W; b++) begin : g_rd
        logic [DEPTH-1:0] column;
        for (genvar s = 0; s < DEPTH; s++) begin : g_col
            assign column[s] = slot_q[s][b];
        end
        assign rd_data[b] = column[rd_idx];
    end

    assign rd_valid = filled_q[rd_idx];

endmodule

// File: rtl/pgwr_timer.sv
module pgwr_timer #(
    parameter int LIMIT = 250000
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     run,
    output logic [$clog2(LIMIT)-1:0] count,
    output logic                     last
);
    localparam int CW = $clog2(LIMIT);
    localparam logic [CW-1:0] END_VAL = CW'(LIMIT - 1);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       count <= '0;
        else if (!run)    count <= '0;
        else if (!last)   count <= count + 1'b1;
    end

    assign last = run && (count == END_VAL);

endmodule

// File: rtl/pgwr_ctrl.sv
module pgwr_ctrl
    import pgwr_pkg::*;
#(
    parameter int ADDR_W = 10,
    parameter int IDX_W  = 4
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    byte_vld,
    input  logic [ADDR_W-1:0]       start_addr,
    input  logic                    stop_stb,
    input  logic                    abort_stb,
    input  logic                    inhibit,
    input  logic [IDX_W-1:0]        scan_idx,
    input  logic                    tmr_last,
    output logic                    buf_clr,
    output logic                    buf_wr,
    output logic [IDX_W-1:0]        buf_idx,
    output logic [ADDR_W-IDX_W-1:0] page_hi,
    output logic                    scan_on,
    output logic                    busy
);
    localparam int HI_W = ADDR_W - IDX_W;

    pg_state_t        state, nxt;
    logic [IDX_W-1:0] nib_q;
    logic [HI_W-1:0]  page_q;
    logic             take_first, take_next;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= nxt;
    end

    // Next-state logic
    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: begin
                if (byte_vld && !abort_stb) nxt = inhibit ? ST_HOLD : ST_FILL;
            end
            ST_FILL: begin
                if (abort_stb)     nxt = ST_IDLE;
                else if (inhibit)  nxt = stop_stb ? ST_IDLE : ST_HOLD;
                else if (stop_stb) nxt = ST_COMMIT;
            end
            ST_HOLD: begin
                if (abort_stb || stop_stb) nxt = ST_IDLE;
            end
            ST_COMMIT: begin
                if (inhibit)              nxt = ST_IDLE;
                else if (scan_idx == '1)  nxt = ST_WAIT;
            end
            ST_WAIT: begin
                if (inhibit || tmr_last) nxt = ST_IDLE;
            end
            default: nxt = ST_IDLE;
        endcase
    end

    // Output logic
    always_comb begin
        take_first = 1'b0;
        take_next  = 1'b0;
        scan_on    = 1'b0;
        busy       = 1'b0;
        buf_idx    = nib_q;
        unique case (state)
            ST_IDLE: begin
                take_first = byte_vld && !abort_stb && !inhibit;
                buf_idx    = start_addr[IDX_W-1:0];
            end
            ST_FILL: begin
                take_next = byte_vld && !abort_stb && !inhibit && !stop_stb;
            end
            ST_HOLD: ;
            ST_COMMIT: begin
                scan_on = 1'b1;
                busy    = 1'b1;
            end
            ST_WAIT: begin
                busy = 1'b1;
            end
            default: ;
        endcase
        buf_clr = take_first;
        buf_wr  = take_first || take_next;
    end

    // Page and slot pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            nib_q  <= '0;
            page_q <= '0;
        end else if (take_first) begin
            page_q <= start_addr[ADDR_W-1:IDX_W];
            nib_q  <= start_addr[IDX_W-1:0] + 1'b1;
        end else if (take_next) begin
            nib_q  <= nib_q + 1'b1;
        end
    end

    assign page_hi = page_q;

endmodule

// File: rtl/pgwr_commit.sv
module pgwr_commit #(
    parameter int ADDR_W     = 10,
    parameter int DATA_W     = 8,
    parameter int IDX_W      = 4,
    parameter int TWR_CYCLES = 250000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              byte_vld,
    input  logic [DATA_W-1:0] byte_data,
    input  logic [ADDR_W-1:0] start_addr,
    input  logic              stop_stb,
    input  logic              abort_stb,
    input  logic              wp,
    input  logic              lv_inhibit,
    output logic              busy,
    output logic              cm_vld,
    output logic [ADDR_W-1:0] cm_addr,
    output logic [DATA_W-1:0] cm_data
);
    localparam int HI_W = ADDR_W - IDX_W;
    localparam int CW   = $clog2(TWR_CYCLES);

    logic                inhibit;
    logic                buf_clr, buf_wr, scan_on, busy_i, tmr_last, rd_valid;
    logic [IDX_W-1:0]    buf_idx, scan_idx;
    logic [HI_W-1:0]     page_hi;
    logic [CW-1:0]       tmr_cnt;
    logic [DATA_W-1:0]   rd_data;

    assign inhibit  = wp || lv_inhibit;
    assign scan_idx = tmr_cnt[IDX_W-1:0];

    pgwr_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) u_ctrl (
        .clk        (clk),
        .rst_n      (rst_n),
        .byte_vld   (byte_vld),
        .start_addr (start_addr),
        .stop_stb   (stop_stb),
        .abort_stb  (abort_stb),
        .inhibit    (inhibit),
        .scan_idx   (scan_idx),
        .tmr_last   (tmr_last),
        .buf_clr    (buf_clr),
        .buf_wr     (buf_wr),
        .buf_idx    (buf_idx),
        .page_hi    (page_hi),
        .scan_on    (scan_on),
        .busy       (busy_i)
    );

    pgwr_buffer #(.DATA_W(DATA_W), .IDX_W(IDX_W)) u_buf (
        .clk      (clk),
        .rst_n    (rst_n),
        .clr      (buf_clr),
        .wr_en    (buf_wr),
        .wr_idx   (buf_idx),
        .wr_data  (byte_data),
        .rd_idx   (scan_idx),
        .rd_data  (rd_data),
        .rd_valid (rd_valid)
    );

    pgwr_timer #(.LIMIT(TWR_CYCLES)) u_tmr (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (busy_i),
        .count (tmr_cnt),
        .last  (tmr_last)
    );

    assign busy    = busy_i;
    assign cm_vld  = scan_on && rd_valid && !inhibit;
    assign cm_addr = {page_hi, scan_idx};
    assign cm_data = rd_data;

endmodule

// File: rtl/pgwr_commit_chk.sv
module pgwr_commit_chk #(
    parameter int ADDR_W     = 10,
    parameter int IDX_W      = 4,
    parameter int TWR_CYCLES = 250000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              stop_stb,
    input logic              wp,
    input logic              lv_inhibit,
    input logic              busy,
    input logic              cm_vld,
    input logic [ADDR_W-1:0] cm_addr
);
    logic [31:0] run_len;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)    run_len <= '0;
        else if (busy) run_len <= run_len + 1;
        else           run_len <= '0;
    end

    // R4: busy starts only after a STOP strobe and never outlasts the programming time
    a_r4_start_on_stop: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(stop_stb));
    a_r4_max_length: assert property (@(posedge clk) disable iff (!rst_n)
        busy |-> (run_len < TWR_CYCLES));

    // R5: commits appear only inside a programming cycle
    a_r5_commit_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        cm_vld |-> busy);

    // R2: back-to-back commits stay in one page with rising slot numbers
    a_r2_ascending: assert property (@(posedge clk) disable iff (!rst_n)
        (cm_vld && $past(cm_vld)) |->
            (cm_addr[ADDR_W-1:IDX_W] == $past(cm_addr[ADDR_W-1:IDX_W])) &&
            (cm_addr[IDX_W-1:0] > $past(cm_addr[IDX_W-1:0])));

    // R10: write protect during a cycle kills it
    a_r10_wp_kills: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && wp) |=> !busy);
    a_r10_wp_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        wp |-> !cm_vld);

    // R11: low-supply inhibit blocks commits and kills the cycle
    a_r11_lv_no_commit: assert property (@(posedge clk) disable iff (!rst_n)
        lv_inhibit |-> !cm_vld);
    a_r11_lv_kills: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && lv_inhibit) |=> !busy);

endmodule

bind pgwr_commit pgwr_commit_chk #(
    .ADDR_W     (ADDR_W),
    .IDX_W      (IDX_W),
    .TWR_CYCLES (TWR_CYCLES)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .stop_stb   (stop_stb),
    .wp         (wp),
    .lv_inhibit (lv_inhibit),
    .busy       (busy),
    .cm_vld     (cm_vld),
    .cm_addr    (cm_addr)
);

// File: tb/test_pgwr_commit.sv
module test_pgwr_commit;
    localparam int TWR = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       byte_vld = 1'b0;
    logic [7:0] byte_data = '0;
    logic [9:0] start_addr = '0;
    logic       stop_stb = 1'b0;
    logic       abort_stb = 1'b0;
    logic       wp = 1'b0;
    logic       lv_inhibit = 1'b0;
    logic       busy, cm_vld;
    logic [9:0] cm_addr;
    logic [7:0] cm_data;

    pgwr_commit #(.TWR_CYCLES(TWR)) i_pgwr_commit (
        .clk(clk), .rst_n(rst_n), .byte_vld(byte_vld), .byte_data(byte_data),
        .start_addr(start_addr), .stop_stb(stop_stb), .abort_stb(abort_stb),
        .wp(wp), .lv_inhibit(lv_inhibit), .busy(busy), .cm_vld(cm_vld),
        .cm_addr(cm_addr), .cm_data(cm_data)
    );

    always #10 clk = ~clk;

    int n_checks = 0;
    int n_errors = 0;

    // Commit monitor, sampled away from the active edge
    logic [9:0] got_addr [64];
    logic [7:0] got_data [64];
    int got_n = 0;
    int busy_cycles = 0;

    always @(negedge clk) begin
        if (busy) busy_cycles++;
        if (cm_vld && got_n < 64) begin
            got_addr[got_n] = cm_addr;
            got_data[got_n] = cm_data;
            got_n++;
        end
    end

    // Reference model of the page store
    logic [7:0] m_data [16];
    logic [15:0] m_fill;
    logic [5:0] m_hi;

    function automatic logic [3:0] slot_of(input logic [9:0] start, input int k);
        return 4'(start[3:0] + k);
    endfunction

    function automatic logic [9:0] addr_of(input logic [5:0] hi, input int s);
        return {hi, 4'(s)};
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_checks++;
        if (!ok) begin
            n_errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic mon_clear();
        got_n = 0;
        busy_cycles = 0;
    endtask

    task automatic pulse_byte(input logic [9:0] a, input logic [7:0] d);
        byte_vld = 1'b1; start_addr = a; byte_data = d;
        tick();
        byte_vld = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_stb = 1'b1;
        tick();
        stop_stb = 1'b0;
    endtask

    task automatic pulse_abort();
        abort_stb = 1'b1;
        tick();
        abort_stb = 1'b0;
    endtask

    // Send n bytes starting at 'start' and track them in the model
    task automatic feed(input logic [9:0] start, input int n);
        m_fill = '0;
        m_hi = start[9:4];
        for (int k = 0; k < n; k++) begin
            logic [7:0] d;
            d = 8'($urandom);
            m_data[slot_of(start, k)] = d;
            m_fill[slot_of(start, k)] = 1'b1;
            pulse_byte(start, d);
        end
    endtask

    // Wait out a full cycle and compare commits and busy length with the model
    task automatic expect_result(input string req, input bit prog);
        int e_n;
        int bad;
        repeat (TWR + 4) tick();
        e_n = 0;
        bad = 0;
        if (prog) begin
            for (int s = 0; s < 16; s++) begin
                if (m_fill[s]) begin
                    if (e_n >= got_n || got_addr[e_n] != addr_of(m_hi, s) ||
                        got_data[e_n] != m_data[s]) bad++;
                    e_n++;
                end
            end
        end
        chk(got_n == e_n, req, "commit count", got_n, e_n);
        chk(bad == 0, req, "commit address/data mismatches", bad, 0);
        chk(busy_cycles == (prog ? TWR : 0), req, "busy cycles", busy_cycles, prog ? TWR : 0);
    endtask

    task automatic finish_run();
        $display("  Simulation finished: %0d checks, %0d errors", n_checks, n_errors);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) tick();
        // R1: reset state
        chk(busy == 1'b0, "R1", "busy after reset", busy, 0);
        chk(cm_vld == 1'b0, "R1", "cm_vld after reset", cm_vld, 0);
        rst_n = 1'b1;
        tick();

        // R2: wrap of the slot number inside the page, starting at slot 14
        mon_clear();
        feed(10'h30E, 4);
        pulse_stop();
        chk(busy == 1'b1, "R4", "busy one cycle after STOP", busy, 1);
        expect_result("R2", 1'b1);
        chk(got_addr[0] == 10'h300, "R2", "first commit address", got_addr[0], 10'h300);
        chk(got_addr[3] == 10'h30F, "R2", "last commit address", got_addr[3], 10'h30F);

        // R3: eighteen bytes overwrite slots 5 and 6
        mon_clear();
        feed(10'h105, 18);
        pulse_stop();
        expect_result("R3", 1'b1);
        chk(got_n == 16, "R3", "full page commit count", got_n, 16);

        // R5: STOP with no byte
        mon_clear();
        pulse_stop();
        expect_result("R5", 1'b0);

        // R7: abort before STOP
        mon_clear();
        feed(10'h040, 3);
        pulse_abort();
        pulse_stop();
        expect_result("R7", 1'b0);

        // R8: wp before the first byte is ignored
        mon_clear();
        wp = 1'b1; tick(); tick(); wp = 1'b0;
        feed(10'h2A3, 5);
        pulse_stop();
        expect_result("R8", 1'b1);

        // R9: wp during collection cancels
        mon_clear();
        feed(10'h011, 2);
        wp = 1'b1; tick(); wp = 1'b0;
        pulse_byte(10'h011, 8'h5A);
        pulse_stop();
        expect_result("R9", 1'b0);

        // R9: wp high on the first byte itself cancels
        mon_clear();
        wp = 1'b1;
        pulse_byte(10'h077, 8'hC3);
        wp = 1'b0;
        pulse_byte(10'h077, 8'h3C);
        pulse_stop();
        expect_result("R9", 1'b0);

        // R11: low-supply inhibit at STOP
        mon_clear();
        feed(10'h155, 3);
        lv_inhibit = 1'b1;
        pulse_stop();
        lv_inhibit = 1'b0;
        expect_result("R11", 1'b0);

        // R6: strobes during busy are ignored
        mon_clear();
        feed(10'h3F0, 6);
        pulse_stop();
        tick();
        pulse_byte(10'h000, 8'hEE);
        pulse_abort();
        pulse_stop();
        pulse_byte(10'h000, 8'hDD);
        expect_result("R6", 1'b1);
        mon_clear();
        pulse_stop();
        expect_result("R6", 1'b0);

        // R10: wp in busy cycle 4 of a full page starting at slot 0
        mon_clear();
        feed(10'h220, 16);
        pulse_stop();
        repeat (4) tick();
        wp = 1'b1;
        tick();
        chk(busy == 1'b0, "R10", "busy after wp", busy, 0);
        wp = 1'b0;
        repeat (TWR) tick();
        chk(got_n == 4, "R10", "commits before kill", got_n, 4);
        chk(got_addr[3] == 10'h223, "R10", "last commit address", got_addr[3], 10'h223);

        // R11: low-supply inhibit in busy cycle 2
        mon_clear();
        feed(10'h180, 16);
        pulse_stop();
        repeat (2) tick();
        lv_inhibit = 1'b1;
        tick();
        chk(busy == 1'b0, "R11", "busy after lv_inhibit", busy, 0);
        lv_inhibit = 1'b0;
        repeat (TWR) tick();
        chk(got_n == 2, "R11", "commits before kill", got_n, 2);

        // R2 R3 R4 R5: random commands
        for (int r = 0; r < 14; r++) begin
            logic [9:0] st;
            int n;
            st = 10'($urandom);
            n = int'($urandom % 21);
            mon_clear();
            feed(st, n);
            pulse_stop();
            expect_result("R5", n > 0);
        end

        finish_run();
    end

endmodule